// File: doc/BRIEF.md
# Serial/Parallel FIFO Output Stage

This block is the output end of a fall-through FIFO. It takes words from the bottom location of the stack. Each word is then offered in one of two ways: as a whole word on a parallel bus, or one bit at a time on a serial line. A status flag, `word_valid`, tells the consumer that the register holds a word it has not yet taken. After reset this flag is LOW, meaning the register holds no valid word.

The parallel transfer request `xfer_par` is a level, not an edge.

- While `xfer_par` is HIGH, the first word to reach the stack bottom is captured.
- The stage then refuses further words until `xfer_par` has been LOW again. This stops the same word from being loaded twice.
- Dropping `xfer_par` clears the flag. The captured word stays on `par_q`.

A serial load happens when `xfer_ser_n` is LOW at the moment a word is taken.

- The serial output enables itself and presents the first bit.
- Each falling edge of the asynchronous `ser_clk` moves one bit out. The clock is synchronized and edge-detected on `clk`.
- The last edge empties the register, clears the flag and disables the serial output.
- If the flag is wired back to `xfer_ser_n`, the stage pulls in the next word on its own.

When several stages are chained, a slave stage keeps its flag LOW until `ser_oe` is raised. A master stage raises its flag as soon as a word is loaded.

The stack side is a valid/ready stream. A word moves on a rising clock edge when `stk_valid` and `stk_ready` are both HIGH. `stk_ready` never depends on `stk_valid`. The stack must hold its word and keep `stk_valid` HIGH until the word is taken. Back-pressure works as follows: `stk_ready` is LOW while `xfer_par` is LOW, and it stays LOW after any load until the register is re-armed. The register is re-armed either by `xfer_par` going LOW outside a serial word, or by the end of a serial word.

Top module: `fifo_out_stage`

## Requirements
- R1: After reset `word_valid` and `ser_q_en` are LOW and `stk_ready` is HIGH whenever `xfer_par` is HIGH.
- R2: With `xfer_par` HIGH and `xfer_ser_n` HIGH, a word offered on the stack side is taken. On the next clock `par_q` holds it and `word_valid` (master) is HIGH.
- R3: In parallel mode, `xfer_par` going LOW drives `word_valid` LOW on the next clock, while `par_q` keeps the word until the next load.
- R4: A word arriving while `xfer_par` is already HIGH is loaded. After a load, `stk_ready` stays LOW, and no further word is taken until `xfer_par` has returned LOW.
- R5: A HIGH pulse on `xfer_par` while no word is offered leaves `word_valid` LOW.
- R6: A load with `xfer_ser_n` LOW is a serial load. On a master, `word_valid` and `ser_q_en` go HIGH and `ser_q` shows bit 0 of the word.
- R7: Each falling edge of `ser_clk` shifts out one bit, bit 0 first and bit W-1 last. After the W-th edge, `word_valid` and `ser_q_en` are LOW.
- R8: With `word_valid` tied to `xfer_ser_n` and `xfer_par` HIGH, successive stack words are loaded and shifted out back to back with no other control activity.
- R9: When `role_master` is LOW, `word_valid` and `ser_q_en` stay LOW after a load until `ser_oe` is HIGH. They then rise on the following clock.
- R10: `par_q_en` is HIGH exactly when `par_oe` is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stk_valid | input | 1 | Stack bottom holds a word |
| stk_data | input | W | Word at the stack bottom |
| stk_ready | output | 1 | Stage will take the offered word this cycle |
| xfer_par | input | 1 | Level transfer request; must be HIGH for any load |
| xfer_ser_n | input | 1 | LOW selects a serial load |
| ser_clk | input | 1 | Asynchronous serial shift clock, falling edge active |
| ser_oe | input | 1 | Releases the status flag of a slave stage |
| role_master | input | 1 | HIGH for a master stage |
| par_oe | input | 1 | Parallel output enable request |
| par_q | output | W | Parallel output word |
| par_q_en | output | 1 | Parallel output drive enable |
| ser_q | output | 1 | Serial output bit |
| ser_q_en | output | 1 | Serial output drive enable |
| word_valid | output | 1 | Register holds an untaken word |

## Verification
The bench holds `xfer_par` HIGH across two queued words. A stage that reacts to the level alone would take the second word at once and overwrite `par_q`. It pulses `xfer_par` with an empty stack, which catches a design that raises the flag without data. It counts serial edges bit by bit, LSB first. An off-by-one count would leave the flag HIGH after the last bit or drop it a bit early, and a reversed shift would show bit W-1 first. It also runs the tied-back self-reload over random words, and a slave whose flag leaks out before its enable would be flagged there.

// File: rtl/fifo_out_pkg.sv
package fifo_out_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } out_mode_e;
endpackage

// File: rtl/fifo_out_fall_det.sv
module fifo_out_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/fifo_out_ctrl.sv
module fifo_out_ctrl
  import fifo_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stk_valid,
  input  logic      xfer_par,
  input  logic      xfer_ser_n,
  input  logic      ser_oe,
  input  logic      role_master,
  input  logic      ser_last,
  output logic      stk_ready,
  output logic      load,
  output logic      full,
  output out_mode_e mode,
  output logic      word_valid,
  output logic      ser_q_en
);
  logic armed_q;
  logic released_q;
  logic shown;

  assign stk_ready  = xfer_par & armed_q;
  assign load       = stk_valid & stk_ready;
  assign shown      = role_master | released_q;
  assign word_valid = full & shown;
  assign ser_q_en   = full & shown & (mode == MODE_SER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full       <= 1'b0;
      armed_q    <= 1'b1;
      released_q <= 1'b0;
      mode       <= MODE_PAR;
    end else if (load) begin
      full       <= 1'b1;
      armed_q    <= 1'b0;
      released_q <= 1'b0;
      mode       <= xfer_ser_n ? MODE_PAR : MODE_SER;
    end else begin
      if (ser_last) begin
        full    <= 1'b0;
        armed_q <= 1'b1;
      end
      if (mode == MODE_PAR && full && !xfer_par) full <= 1'b0;
      if (!xfer_par && !(full && mode == MODE_SER)) armed_q <= 1'b1;
      if (ser_oe && full) released_q <= 1'b1;
    end
  end

  // R2: a taken word makes the register full
  p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full);
  // R4: no second word straight after a load
  p_no_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !stk_ready);
  // R3: parallel word released when the request drops
  p_par_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && mode == MODE_PAR && !xfer_par) |=> !word_valid);
  // R9: a slave never shows its word before release
  p_slave_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !role_master) |=> !word_valid);
endmodule

// File: rtl/fifo_out_shift.sv
module fifo_out_shift #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_ok,
  output logic [W-1:0] par_word,
  output logic         ser_bit,
  output logic         ser_last
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sreg_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word <= '0;
      sreg_q   <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      par_word <= load_data;
      sreg_q   <= load_data;
      cnt_q    <= '0;
    end else if (shift_ok) begin
      sreg_q <= {1'b0, sreg_q[W-1:1]};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign ser_bit  = sreg_q[0];
  assign ser_last = shift_ok & (cnt_q == LAST);

  // R7: the edge count never runs past the word width
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(W));
  // R3: parallel word only changes on a load
  p_par_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(par_word));
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
  import fifo_out_pkg::*;
#(
  parameter int W         = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stk_valid,
  input  logic [W-1:0] stk_data,
  output logic         stk_ready,
  input  logic         xfer_par,
  input  logic         xfer_ser_n,
  input  logic         ser_clk,
  input  logic         ser_oe,
  input  logic         role_master,
  input  logic         par_oe,
  output logic [W-1:0] par_q,
  output logic         par_q_en,
  output logic         ser_q,
  output logic         ser_q_en,
  output logic         word_valid
);
  logic      fall;
  logic      load;
  logic      full;
  logic      ser_last;
  logic      shift_ok;
  out_mode_e mode;

  fifo_out_fall_det #(.STAGES(SYNC_STG)) u_fall (
    .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .fall(fall)
  );

  fifo_out_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .stk_valid(stk_valid), .xfer_par(xfer_par),
    .xfer_ser_n(xfer_ser_n), .ser_oe(ser_oe), .role_master(role_master),
    .ser_last(ser_last), .stk_ready(stk_ready), .load(load), .full(full),
    .mode(mode), .word_valid(word_valid), .ser_q_en(ser_q_en)
  );

  assign shift_ok = fall & full & (mode == MODE_SER) & ~load;

  fifo_out_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(stk_data),
    .shift_ok(shift_ok), .par_word(par_q), .ser_bit(ser_q),
    .ser_last(ser_last)
  );

  assign par_q_en = par_oe;

  // R6: serial drive only while a visible word is held
  p_ser_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_q_en |-> word_valid);
  // R7: last shift edge empties the register
  p_ser_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_last |=> !ser_q_en);
endmodule

// File: tb/test_fifo_out_stage.sv
module test_fifo_out_stage;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         xfer_par = 1'b0;
  logic         ser_n_drv = 1'b1;
  logic         tie = 1'b0;
  logic         ser_clk = 1'b1;
  logic         ser_oe = 1'b0;
  logic         role_master = 1'b1;
  logic         par_oe = 1'b0;
  logic         stk_ready, par_q_en, ser_q, ser_q_en, word_valid;
  logic [W-1:0] par_q;
  logic         xfer_ser_n;

  logic [W-1:0] q_mem [64];
  int           head = 0;
  int           tail = 0;
  logic         stk_valid;
  logic [W-1:0] stk_data;

  int n_chk = 0;
  int n_bad = 0;

  assign stk_valid  = head < tail;
  assign stk_data   = q_mem[head % 64];
  assign xfer_ser_n = tie ? word_valid : ser_n_drv;

  always #5 clk = ~clk;

  fifo_out_stage #(.W(W)) i_fifo_out_stage (
    .clk(clk), .rst_n(rst_n), .stk_valid(stk_valid), .stk_data(stk_data),
    .stk_ready(stk_ready), .xfer_par(xfer_par), .xfer_ser_n(xfer_ser_n),
    .ser_clk(ser_clk), .ser_oe(ser_oe), .role_master(role_master),
    .par_oe(par_oe), .par_q(par_q), .par_q_en(par_q_en), .ser_q(ser_q),
    .ser_q_en(ser_q_en), .word_valid(word_valid)
  );

  always @(posedge clk) if (stk_valid && stk_ready) head <= head + 1;

  function automatic logic exp_bit(logic [W-1:0] w, int i);
    return w[i];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [W-1:0] w);
    q_mem[tail % 64] = w;
    tail++;
  endtask

  task automatic sclk_pulse();
    ser_clk = 1'b1; cyc(4);
    ser_clk = 1'b0; cyc(4);
  endtask

  // shift one word out, checking each bit, LSB first
  task automatic ser_word(logic [W-1:0] w, string req);
    for (int i = 0; i < W; i++) begin
      check(req, ser_q, exp_bit(w, i));
      check(req, ser_q_en, 1'b1);
      sclk_pulse();
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, w;
    void'($urandom(32'h1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1", word_valid, 0);
    check("R1", ser_q_en, 0);
    xfer_par = 1'b1; cyc(1);
    check("R1", stk_ready, 1);
    // R5 request pulse with empty stack
    cyc(2); xfer_par = 1'b0; cyc(2);
    check("R5", word_valid, 0);
    // R10 enable follows request
    par_oe = 1'b1; #1 check("R10", par_q_en, 1);
    par_oe = 1'b0; #1 check("R10", par_q_en, 0);
    // R4 data arrives while request is already high
    a = 4'hA; b = 4'h5;
    xfer_par = 1'b1; cyc(3);
    push(a); cyc(2);
    check("R2", word_valid, 1);
    check("R4", par_q, a);
    push(b); cyc(3);
    check("R4", par_q, a);
    check("R4", stk_ready, 0);
    check("R4", tail - head, 1);
    // R3 dropping the request
    xfer_par = 1'b0; cyc(2);
    check("R3", word_valid, 0);
    check("R3", par_q, a);
    xfer_par = 1'b1; cyc(2);
    check("R2", par_q, b);
    xfer_par = 1'b0; cyc(2);
    // R2/R3 random parallel words
    for (int k = 0; k < 20; k++) begin
      w = W'($urandom);
      push(w);
      cyc(1 + ($urandom % 3));
      xfer_par = 1'b1; cyc(2);
      check("R2", word_valid, 1);
      check("R2", par_q, w);
      xfer_par = 1'b0; cyc(2);
      check("R3", word_valid, 0);
      check("R3", par_q, w);
    end
    // R6/R7 single serial word on a master
    ser_n_drv = 1'b0; xfer_par = 1'b1;
    w = 4'b1101; push(w); cyc(2);
    check("R6", word_valid, 1);
    ser_n_drv = 1'b1;
    ser_word(w, "R7");
    check("R7", word_valid, 0);
    check("R7", ser_q_en, 0);
    // R8 self reload through the tie-back
    xfer_par = 1'b0; cyc(2);
    xfer_par = 1'b1; tie = 1'b1;
    for (int k = 0; k < 12; k++) begin
      w = W'($urandom);
      push(w);
      cyc(3);
      check("R8", word_valid, 1);
      ser_word(w, "R8");
      check("R8", word_valid, 0);
    end
    // R9 slave holds its flag until released
    role_master = 1'b0;
    w = W'($urandom); push(w); cyc(3);
    check("R9", word_valid, 0);
    check("R9", ser_q_en, 0);
    check("R9", tail - head, 0);
    ser_oe = 1'b1; cyc(2);
    check("R9", word_valid, 1);
    check("R9", ser_q_en, 1);
    ser_word(w, "R9");
    check("R9", word_valid, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule